// File: doc/BRIEF.md
# Single-Flag Integer Execute Unit

This block is the execute stage of a 32-bit integer datapath that keeps exactly one condition bit, called C here. Each cycle it receives an operation code, two register operands A and B and an immediate. It returns a 32-bit result, a write-enable for the destination register and the value C will take at the next clock edge. The C bit itself is held in a register inside the block and is also visible on an output.

Most arithmetic writes a register and leaves C alone. Compares, the zero-byte test, the decrement-and-test group and the two carry-using arithmetic forms write C. Several operations are predicated on C: they write the destination only when C holds the required value, and otherwise produce no write. Decode, the register file, multiply, divide and memory access sit outside this block.

Top module: `sfx_exec`

## Requirements
- R1: While `rst_n` is low, `c_flag` is 0, and asserting `rst_n` low clears `c_flag` at once without a clock edge; op code 0 is a no-operation with `res_we` = 0 and C kept.
- R2: Op 1 gives A+B, op 2 gives A+imm, op 4 gives A-B, op 5 gives A-imm, op 7 gives B-A and op 8 gives imm-A (all modulo 2^32), each with `res_we` = 1 and C unchanged.
- R3: Op 3 gives A+B+C with the new C equal to the carry out of bit 31; op 6 gives A-B-(1-C), where C = 1 means no borrow, with the new C equal to 1 when no borrow occurs; both write the result.
- R4: Unsigned compares set C and write nothing: op 9 sets C when A >= B, op 12 when A != B, op 13 when A != imm.
- R5: Signed two's-complement compares set C and write nothing: op 10 sets C when A < B, op 11 when A < imm.
- R6: Op 14 writes B to the destination only when C = 1, op 15 only when C = 0; otherwise `res_we` = 0. C is unchanged.
- R7: Op 16 writes C into bit 0 and zeros into bits 31..1; op 17 writes the complement of C likewise. C is unchanged.
- R8: Op 18 sets C when none of the four bytes of A (bits 7..0, 15..8, 23..16, 31..24) is zero, clears it otherwise, and writes nothing.
- R9: Op 19 writes zero when C = 1 and op 20 when C = 0; otherwise `res_we` = 0. C is unchanged.
- R10: Ops 21 and 22 write A+1 when C is 1 or 0 respectively; ops 23 and 24 write A-1 under the same conditions; otherwise `res_we` = 0, and C never changes.
- R11: Ops 25, 26 and 27 always write A-1 and set C when A-1, read as signed, is greater than zero, less than zero, or not zero respectively.
- R12: `result`, `res_we` and `c_next` depend combinationally on the inputs and the held C; `c_flag` takes the value of `c_next` at each rising clock edge; op codes 28 to 31 write nothing and keep C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| op | input | 5 | Operation code |
| opa | input | 32 | Register operand A |
| opb | input | 32 | Register operand B |
| imm | input | 32 | Immediate operand |
| result | output | 32 | Value for the destination register |
| res_we | output | 1 | Destination write-enable |
| c_next | output | 1 | Value C takes at the next rising edge |
| c_flag | output | 1 | Held condition bit C |

## Verification
The result, the write-enable and the next C are due in the same cycle the operation is presented, since no register lies on those paths; the held C is due one rising edge later. The bench drives each operation on a falling edge, samples the combinational outputs one nanosecond later, and samples `c_flag` at the following falling edge, after exactly one rising edge. Before every vector the bench puts C into a known state with a not-equal compare, so predicated operations are tried with both values of C.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

  localparam int OP_W   = 5;
  localparam int WORD_W = 32;

  typedef enum logic [OP_W-1:0] {
    OP_NOP          = 5'd0,
    OP_ADD          = 5'd1,
    OP_ADD_IMM      = 5'd2,
    OP_ADD_CY       = 5'd3,
    OP_SUB          = 5'd4,
    OP_SUB_IMM      = 5'd5,
    OP_SUB_CY       = 5'd6,
    OP_RSB          = 5'd7,
    OP_RSB_IMM      = 5'd8,
    OP_CMP_GEU      = 5'd9,
    OP_CMP_LTS      = 5'd10,
    OP_CMP_LTS_IMM  = 5'd11,
    OP_CMP_NE       = 5'd12,
    OP_CMP_NE_IMM   = 5'd13,
    OP_SEL_IF_SET   = 5'd14,
    OP_SEL_IF_CLR   = 5'd15,
    OP_FLAG_TO_REG  = 5'd16,
    OP_NFLAG_TO_REG = 5'd17,
    OP_NO_ZERO_BYTE = 5'd18,
    OP_ZERO_IF_SET  = 5'd19,
    OP_ZERO_IF_CLR  = 5'd20,
    OP_INC_IF_SET   = 5'd21,
    OP_INC_IF_CLR   = 5'd22,
    OP_DEC_IF_SET   = 5'd23,
    OP_DEC_IF_CLR   = 5'd24,
    OP_DEC_TEST_GT  = 5'd25,
    OP_DEC_TEST_LT  = 5'd26,
    OP_DEC_TEST_NE  = 5'd27
  } op_e;

endpackage

// File: rtl/sfx_arith.sv
// Add/subtract family on one shared adder: plain, immediate, carry and
// reversed forms. Subtraction is done as x + ~y + 1.
module sfx_arith
  import sfx_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [W-1:0]    imm,
  input  logic            c_in,
  output logic            hit,
  output logic            flag_wr,
  output logic [W-1:0]    sum,
  output logic            carry
);

  logic [W-1:0] x;
  logic [W-1:0] y;
  logic         ci;
  logic [W:0]   total;

  always_comb begin
    hit     = 1'b1;
    flag_wr = 1'b0;
    x       = a;
    y       = b;
    ci      = 1'b0;
    case (op)
      OP_ADD:     begin x = a;   y = b;    ci = 1'b0; end
      OP_ADD_IMM: begin x = a;   y = imm;  ci = 1'b0; end
      OP_ADD_CY:  begin x = a;   y = b;    ci = c_in; flag_wr = 1'b1; end
      OP_SUB:     begin x = a;   y = ~b;   ci = 1'b1; end
      OP_SUB_IMM: begin x = a;   y = ~imm; ci = 1'b1; end
      OP_SUB_CY:  begin x = a;   y = ~b;   ci = c_in; flag_wr = 1'b1; end
      OP_RSB:     begin x = b;   y = ~a;   ci = 1'b1; end
      OP_RSB_IMM: begin x = imm; y = ~a;   ci = 1'b1; end
      default:    hit = 1'b0;
    endcase
  end

  assign total = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  assign sum   = total[W-1:0];
  assign carry = total[W];

endmodule

// File: rtl/sfx_cond.sv
// Operations that always write C: compares, zero-byte test and the
// decrement-and-test group (the latter also write the register).
module sfx_cond
  import sfx_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [W-1:0]    imm,
  output logic            hit,
  output logic            c_new,
  output logic            wr,
  output logic [W-1:0]    val
);

  localparam int NB = W / 8;

  logic [NB-1:0] byte_nz;
  logic [W-1:0]  dec;
  logic          dec_zero;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign byte_nz[g] = |a[8*g +: 8];
  end

  assign dec      = a - {{(W-1){1'b0}}, 1'b1};
  assign dec_zero = (dec == '0);
  assign val      = dec;

  always_comb begin
    hit   = 1'b1;
    wr    = 1'b0;
    c_new = 1'b0;
    case (op)
      OP_CMP_GEU:      c_new = (a >= b);
      OP_CMP_LTS:      c_new = ($signed(a) < $signed(b));
      OP_CMP_LTS_IMM:  c_new = ($signed(a) < $signed(imm));
      OP_CMP_NE:       c_new = (a != b);
      OP_CMP_NE_IMM:   c_new = (a != imm);
      OP_NO_ZERO_BYTE: c_new = &byte_nz;
      OP_DEC_TEST_GT:  begin wr = 1'b1; c_new = !dec[W-1] && !dec_zero; end
      OP_DEC_TEST_LT:  begin wr = 1'b1; c_new = dec[W-1]; end
      OP_DEC_TEST_NE:  begin wr = 1'b1; c_new = !dec_zero; end
      default:         hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/sfx_pred.sv
// Operations that read C but never change it: predicated select, clear,
// increment and decrement, and copying C into a register.
module sfx_pred
  import sfx_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic            c_in,
  output logic [W-1:0]    res,
  output logic            we
);

  logic [W-1:0] plus1;
  logic [W-1:0] minus1;

  assign plus1  = a + {{(W-1){1'b0}}, 1'b1};
  assign minus1 = a - {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    res = '0;
    we  = 1'b0;
    case (op)
      OP_SEL_IF_SET:   begin res = b;      we = c_in;  end
      OP_SEL_IF_CLR:   begin res = b;      we = !c_in; end
      OP_FLAG_TO_REG:  begin res = {{(W-1){1'b0}}, c_in};  we = 1'b1; end
      OP_NFLAG_TO_REG: begin res = {{(W-1){1'b0}}, !c_in}; we = 1'b1; end
      OP_ZERO_IF_SET:  begin res = '0;     we = c_in;  end
      OP_ZERO_IF_CLR:  begin res = '0;     we = !c_in; end
      OP_INC_IF_SET:   begin res = plus1;  we = c_in;  end
      OP_INC_IF_CLR:   begin res = plus1;  we = !c_in; end
      OP_DEC_IF_SET:   begin res = minus1; we = c_in;  end
      OP_DEC_IF_CLR:   begin res = minus1; we = !c_in; end
      default:         begin res = '0;     we = 1'b0;  end
    endcase
  end

endmodule

// File: rtl/sfx_exec.sv
// Execute stage with a single held condition bit.
module sfx_exec
  import sfx_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic [W-1:0]    imm,
  output logic [W-1:0]    result,
  output logic            res_we,
  output logic            c_next,
  output logic            c_flag
);

  logic         c_q;
  logic         c_wr;
  logic         c_new;

  logic         ar_hit;
  logic         ar_flag;
  logic [W-1:0] ar_sum;
  logic         ar_carry;

  logic         cd_hit;
  logic         cd_c;
  logic         cd_wr;
  logic [W-1:0] cd_val;

  logic [W-1:0] pr_res;
  logic         pr_we;

  sfx_arith #(.W(W)) arith_i (
    .op      (op),
    .a       (opa),
    .b       (opb),
    .imm     (imm),
    .c_in    (c_q),
    .hit     (ar_hit),
    .flag_wr (ar_flag),
    .sum     (ar_sum),
    .carry   (ar_carry)
  );

  sfx_cond #(.W(W)) cond_i (
    .op    (op),
    .a     (opa),
    .b     (opb),
    .imm   (imm),
    .hit   (cd_hit),
    .c_new (cd_c),
    .wr    (cd_wr),
    .val   (cd_val)
  );

  sfx_pred #(.W(W)) pred_i (
    .op   (op),
    .a    (opa),
    .b    (opb),
    .c_in (c_q),
    .res  (pr_res),
    .we   (pr_we)
  );

  // Next-state selection
  always_comb begin
    result = '0;
    res_we = 1'b0;
    c_wr   = 1'b0;
    c_new  = c_q;
    if (ar_hit) begin
      result = ar_sum;
      res_we = 1'b1;
      if (ar_flag) begin
        c_wr  = 1'b1;
        c_new = ar_carry;
      end
    end else if (cd_hit) begin
      result = cd_val;
      res_we = cd_wr;
      c_wr   = 1'b1;
      c_new  = cd_c;
    end else begin
      result = pr_res;
      res_we = pr_we;
    end
  end

  assign c_next = c_wr ? c_new : c_q;

  // Condition register with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= 1'b0;
    end else if (c_wr) begin
      c_q <= c_new;
    end
  end

  assign c_flag = c_q;

endmodule

// File: rtl/sfx_exec_chk.sv
module sfx_exec_chk
  import sfx_pkg::*;
#(
  parameter int W = WORD_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic [OP_W-1:0] op,
  input logic [W-1:0]    result,
  input logic            res_we,
  input logic            c_next,
  input logic            c_flag
);

  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  logic plain_op;
  assign plain_op = (op == OP_ADD) || (op == OP_ADD_IMM) || (op == OP_SUB) ||
                    (op == OP_SUB_IMM) || (op == OP_RSB) || (op == OP_RSB_IMM);

  logic cmp_op;
  assign cmp_op = (op == OP_CMP_GEU) || (op == OP_CMP_LTS) || (op == OP_CMP_LTS_IMM) ||
                  (op == OP_CMP_NE) || (op == OP_CMP_NE_IMM) || (op == OP_NO_ZERO_BYTE);

  // R12
  c_reg_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (c_flag == $past(c_next)));

  // R2
  plain_keeps_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(plain_op)) |-> (c_flag == $past(c_flag)));

  // R4 R5 R8
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_op |-> !res_we);

  // R6
  sel_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((op == OP_SEL_IF_SET) && !c_flag) || ((op == OP_SEL_IF_CLR) && c_flag)) |-> !res_we);

  // R7
  flag_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FLAG_TO_REG) |-> (res_we && (result == {{(W-1){1'b0}}, c_flag})));

endmodule

bind sfx_exec sfx_exec_chk #(.W(W)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .op     (op),
  .result (result),
  .res_we (res_we),
  .c_next (c_next),
  .c_flag (c_flag)
);

// File: tb/sfx_exec_tb.sv
module sfx_exec_tb_top;

  logic        clk;
  logic        rst_n;
  logic [4:0]  op;
  logic [31:0] opa, opb, imm;
  logic [31:0] result;
  logic        res_we, c_next, c_flag;

  int n_chk;
  int n_bad;
  bit done;

  sfx_exec dut_i (
    .clk(clk), .rst_n(rst_n), .op(op), .opa(opa), .opb(opb), .imm(imm),
    .result(result), .res_we(res_we), .c_next(c_next), .c_flag(c_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [4:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] imm;
    logic        cin;
    logic [31:0] res;
    logic        we;
    logic        cout;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 52;
  localparam vec_t VEC [NV] = '{
    // R2 plain arithmetic
    {5'd1,  32'h7FFFFFFF, 32'h00000001, 32'h0,        1'b0, 32'h80000000, 1'b1, 1'b0, 4'd2},
    {5'd1,  32'hFFFFFFFF, 32'h00000002, 32'h0,        1'b1, 32'h00000001, 1'b1, 1'b1, 4'd2},
    {5'd2,  32'h00000010, 32'h0,        32'hFFFFFFF0, 1'b0, 32'h00000000, 1'b1, 1'b0, 4'd2},
    {5'd4,  32'h00000005, 32'h00000007, 32'h0,        1'b1, 32'hFFFFFFFE, 1'b1, 1'b1, 4'd2},
    {5'd5,  32'h80000000, 32'h0,        32'h00000001, 1'b0, 32'h7FFFFFFF, 1'b1, 1'b0, 4'd2},
    {5'd7,  32'h00000003, 32'h00000010, 32'h0,        1'b0, 32'h0000000D, 1'b1, 1'b0, 4'd2},
    {5'd8,  32'h00000005, 32'h0,        32'h00000002, 1'b1, 32'hFFFFFFFD, 1'b1, 1'b1, 4'd2},
    // R3 carry forms
    {5'd3,  32'hFFFFFFFF, 32'h00000000, 32'h0,        1'b1, 32'h00000000, 1'b1, 1'b1, 4'd3},
    {5'd3,  32'h00000001, 32'h00000002, 32'h0,        1'b1, 32'h00000004, 1'b1, 1'b0, 4'd3},
    {5'd3,  32'h7FFFFFFF, 32'h80000000, 32'h0,        1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd3},
    {5'd6,  32'h00000005, 32'h00000003, 32'h0,        1'b1, 32'h00000002, 1'b1, 1'b1, 4'd3},
    {5'd6,  32'h00000005, 32'h00000005, 32'h0,        1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd3},
    {5'd6,  32'h00000000, 32'h00000000, 32'h0,        1'b1, 32'h00000000, 1'b1, 1'b1, 4'd3},
    // R4 unsigned compares
    {5'd9,  32'h80000000, 32'h7FFFFFFF, 32'h0,        1'b0, 32'h0,        1'b0, 1'b1, 4'd4},
    {5'd9,  32'h00000003, 32'h00000003, 32'h0,        1'b0, 32'h0,        1'b0, 1'b1, 4'd4},
    {5'd9,  32'h00000002, 32'h00000003, 32'h0,        1'b1, 32'h0,        1'b0, 1'b0, 4'd4},
    {5'd12, 32'h00000004, 32'h00000004, 32'h0,        1'b1, 32'h0,        1'b0, 1'b0, 4'd4},
    {5'd13, 32'h00000004, 32'h0,        32'h00000005, 1'b0, 32'h0,        1'b0, 1'b1, 4'd4},
    // R5 signed compares
    {5'd10, 32'h80000000, 32'h7FFFFFFF, 32'h0,        1'b0, 32'h0,        1'b0, 1'b1, 4'd5},
    {5'd10, 32'h7FFFFFFF, 32'h80000000, 32'h0,        1'b1, 32'h0,        1'b0, 1'b0, 4'd5},
    {5'd11, 32'hFFFFFFFF, 32'h0,        32'h00000000, 1'b0, 32'h0,        1'b0, 1'b1, 4'd5},
    {5'd11, 32'h00000000, 32'h0,        32'h00000000, 1'b1, 32'h0,        1'b0, 1'b0, 4'd5},
    // R6 predicated select
    {5'd14, 32'h0,        32'hDEADBEEF, 32'h0,        1'b1, 32'hDEADBEEF, 1'b1, 1'b1, 4'd6},
    {5'd14, 32'h0,        32'hDEADBEEF, 32'h0,        1'b0, 32'h0,        1'b0, 1'b0, 4'd6},
    {5'd15, 32'h0,        32'h12345678, 32'h0,        1'b0, 32'h12345678, 1'b1, 1'b0, 4'd6},
    {5'd15, 32'h0,        32'h12345678, 32'h0,        1'b1, 32'h0,        1'b0, 1'b1, 4'd6},
    // R7 flag into register
    {5'd16, 32'hFFFFFFFF, 32'h0,        32'h0,        1'b1, 32'h00000001, 1'b1, 1'b1, 4'd7},
    {5'd16, 32'hFFFFFFFF, 32'h0,        32'h0,        1'b0, 32'h00000000, 1'b1, 1'b0, 4'd7},
    {5'd17, 32'hFFFFFFFF, 32'h0,        32'h0,        1'b0, 32'h00000001, 1'b1, 1'b0, 4'd7},
    {5'd17, 32'hFFFFFFFF, 32'h0,        32'h0,        1'b1, 32'h00000000, 1'b1, 1'b1, 4'd7},
    // R8 zero-byte test
    {5'd18, 32'h00FFFFFF, 32'h0,        32'h0,        1'b1, 32'h0,        1'b0, 1'b0, 4'd8},
    {5'd18, 32'h01010101, 32'h0,        32'h0,        1'b0, 32'h0,        1'b0, 1'b1, 4'd8},
    {5'd18, 32'hFFFF00FF, 32'h0,        32'h0,        1'b1, 32'h0,        1'b0, 1'b0, 4'd8},
    // R9 conditional clear
    {5'd19, 32'h00000055, 32'h0,        32'h0,        1'b1, 32'h00000000, 1'b1, 1'b1, 4'd9},
    {5'd19, 32'h00000055, 32'h0,        32'h0,        1'b0, 32'h0,        1'b0, 1'b0, 4'd9},
    {5'd20, 32'h00000055, 32'h0,        32'h0,        1'b0, 32'h00000000, 1'b1, 1'b0, 4'd9},
    {5'd20, 32'h00000055, 32'h0,        32'h0,        1'b1, 32'h0,        1'b0, 1'b1, 4'd9},
    // R10 conditional increment / decrement
    {5'd21, 32'hFFFFFFFF, 32'h0,        32'h0,        1'b1, 32'h00000000, 1'b1, 1'b1, 4'd10},
    {5'd22, 32'h7FFFFFFF, 32'h0,        32'h0,        1'b0, 32'h80000000, 1'b1, 1'b0, 4'd10},
    {5'd22, 32'h7FFFFFFF, 32'h0,        32'h0,        1'b1, 32'h0,        1'b0, 1'b1, 4'd10},
    {5'd23, 32'h00000000, 32'h0,        32'h0,        1'b1, 32'hFFFFFFFF, 1'b1, 1'b1, 4'd10},
    {5'd24, 32'h80000000, 32'h0,        32'h0,        1'b0, 32'h7FFFFFFF, 1'b1, 1'b0, 4'd10},
    {5'd23, 32'h00000000, 32'h0,        32'h0,        1'b0, 32'h0,        1'b0, 1'b0, 4'd10},
    // R11 decrement and test
    {5'd25, 32'h00000002, 32'h0,        32'h0,        1'b0, 32'h00000001, 1'b1, 1'b1, 4'd11},
    {5'd25, 32'h00000001, 32'h0,        32'h0,        1'b1, 32'h00000000, 1'b1, 1'b0, 4'd11},
    {5'd25, 32'h80000000, 32'h0,        32'h0,        1'b1, 32'h7FFFFFFF, 1'b1, 1'b1, 4'd11},
    {5'd26, 32'h00000000, 32'h0,        32'h0,        1'b0, 32'hFFFFFFFF, 1'b1, 1'b1, 4'd11},
    {5'd26, 32'h80000000, 32'h0,        32'h0,        1'b1, 32'h7FFFFFFF, 1'b1, 1'b0, 4'd11},
    {5'd27, 32'h00000001, 32'h0,        32'h0,        1'b1, 32'h00000000, 1'b1, 1'b0, 4'd11},
    {5'd27, 32'h00000000, 32'h0,        32'h0,        1'b0, 32'hFFFFFFFF, 1'b1, 1'b1, 4'd11},
    // R12 idle and unused codes
    {5'd0,  32'h12345678, 32'h9ABCDEF0, 32'h1,        1'b1, 32'h0,        1'b0, 1'b1, 4'd12},
    {5'd31, 32'h12345678, 32'h9ABCDEF0, 32'h1,        1'b0, 32'h0,        1'b0, 1'b0, 4'd12}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Put C into a known state through a not-equal compare (op 12).
  task automatic set_c(input logic v);
    op  = 5'd12;
    opa = {31'b0, v};
    opb = 32'h0;
    imm = 32'h0;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    op    = 5'd0;
    opa   = 32'h0;
    opb   = 32'h0;
    imm   = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state and idle op
    check("R1 c_flag in reset", {31'b0, c_flag}, 32'h0);
    check("R1 no write on idle", {31'b0, res_we}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 c_flag after release", {31'b0, c_flag}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d op%0d", VEC[i].req, i, VEC[i].op);
      set_c(VEC[i].cin);
      op  = VEC[i].op;
      opa = VEC[i].a;
      opb = VEC[i].b;
      imm = VEC[i].imm;
      #1;
      check({tag, " we"}, {31'b0, res_we}, {31'b0, VEC[i].we});
      if (VEC[i].we) check({tag, " result"}, result, VEC[i].res);
      check({tag, " c_next"}, {31'b0, c_next}, {31'b0, VEC[i].cout});
      @(posedge clk);
      @(negedge clk);
      check({tag, " c_flag"}, {31'b0, c_flag}, {31'b0, VEC[i].cout});
    end

    // R12 held C keeps across several idle cycles
    set_c(1'b1);
    op = 5'd0;
    repeat (4) @(negedge clk);
    check("R12 C held over idle", {31'b0, c_flag}, 32'h1);

    // R1 asynchronous clear in mid-cycle
    #1;
    rst_n = 1'b0;
    #0.5;
    check("R1 async clear", {31'b0, c_flag}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 carry chain over two cycles: C from first add feeds second
    op = 5'd3; opa = 32'hFFFFFFFF; opb = 32'h00000001; imm = 32'h0;
    #1;
    check("R3 chain low word", result, 32'h00000000);
    @(posedge clk);
    @(negedge clk);
    op = 5'd3; opa = 32'h00000010; opb = 32'h00000020;
    #1;
    check("R3 chain high word", result, 32'h00000031);
    check("R3 chain carry out", {31'b0, c_next}, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule